// File: doc/BRIEF.md
# Clustered Replicated Register File

This block is the architectural register file for an issue pipeline that is `N_ISSUE` instructions wide and whose execution units are split into `N_CLUSTER` groups. Rather than a single array with `2*N_ISSUE` read ports, it keeps one full copy of the registers per cluster. Each copy feeds operands only to its own cluster, so it needs only `2*N_ISSUE/N_CLUSTER` read ports. Every write is applied to all copies at the same clock edge, so the copies always hold the same values.

Writes come in on `N_ISSUE` ports, one per instruction that retires a register result. A higher-numbered port carries a younger instruction. A read that targets a register being written in the same cycle sees the new value. Register 0 is hard-wired to zero. The network that forwards values between clusters and the steering of instructions to clusters are handled outside this block.

Top module: `cluster_regfile`

## Requirements
- R1: After reset every register reads as zero on every read port.
- R2: A value written on any write port at a clock edge is returned afterwards by every read port of every cluster that addresses that register.
- R3: A read in the same cycle as an enabled write to the same nonzero register returns the data being written, not the stored value.
- R4: When several enabled write ports target the same register in one cycle, the highest-numbered port's data is the one forwarded in that cycle and the one stored in every copy.
- R5: Register 0 always reads as zero, and writes addressed to it are dropped.
- R6: Read port p of cluster c uses flat lane index c*(2*N_ISSUE/N_CLUSTER)+p: its address is rd_addr[idx*AW +: AW] and its data is rd_data[idx*DATA_W +: DATA_W]. Each port is addressed independently. Write port w uses wr_en[w], wr_addr[w*AW +: AW] and wr_data[w*DATA_W +: DATA_W].
- R7: A write port whose wr_en bit is low changes no register, whatever its address and data.
- R8: Any two read ports, in the same cluster or in different clusters, that address the same register in the same cycle return identical data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all copies |
| wr_en | input | N_ISSUE | Write enable per write port |
| wr_addr | input | N_ISSUE*AW | Register index per write port |
| wr_data | input | N_ISSUE*DATA_W | Write data per write port |
| rd_addr | input | 2*N_ISSUE*AW | Register index per read lane, grouped by cluster |
| rd_data | output | 2*N_ISSUE*DATA_W | Read data per read lane, combinational |

## Verification
The bench first walks every register: it writes each one through a rotating write port and then reads it back on all eight lanes. This separates a missing broadcast to one copy from a missing store. It then drives a spread of different addresses across the lanes to catch swapped lane slicing. Same-cycle write/read pairs on every write port tell forwarding apart from stale storage. Collisions between all ports, between two ports, and with the top port disabled show whether the younger port wins both in the forwarded value and in the stored copy. Writes to register 0, and fully driven ports with their enable low, confirm that nothing leaks into storage.

// File: rtl/cluster_regfile.sv
module cluster_regfile #(
  parameter int N_ISSUE   = 4,
  parameter int N_CLUSTER = 2,
  parameter int N_REGS    = 32,
  parameter int DATA_W    = 32,
  localparam int AW       = $clog2(N_REGS),
  localparam int RD_PER_CL = 2 * N_ISSUE / N_CLUSTER,
  localparam int N_RD     = 2 * N_ISSUE
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_ISSUE-1:0]         wr_en,
  input  logic [N_ISSUE*AW-1:0]      wr_addr,
  input  logic [N_ISSUE*DATA_W-1:0]  wr_data,
  input  logic [N_RD*AW-1:0]         rd_addr,
  output logic [N_RD*DATA_W-1:0]     rd_data
);

  logic [AW-1:0]     wa [N_ISSUE];
  logic [DATA_W-1:0] wd [N_ISSUE];

  for (genvar w = 0; w < N_ISSUE; w++) begin : g_wport
    assign wa[w] = wr_addr[w*AW +: AW];
    assign wd[w] = wr_data[w*DATA_W +: DATA_W];
  end

  for (genvar c = 0; c < N_CLUSTER; c++) begin : g_cl
    logic [DATA_W-1:0] mem [N_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < N_REGS; r++) mem[r] <= '0;
      end else begin
        for (int w = 0; w < N_ISSUE; w++)
          if (wr_en[w] && wa[w] != '0) mem[wa[w]] <= wd[w];
      end
    end

    for (genvar p = 0; p < RD_PER_CL; p++) begin : g_rd
      localparam int IDX = c * RD_PER_CL + p;
      logic [AW-1:0]     ra;
      logic [DATA_W-1:0] val;

      assign ra = rd_addr[IDX*AW +: AW];

      always_comb begin
        val = mem[ra];
        for (int w = 0; w < N_ISSUE; w++)
          if (wr_en[w] && wa[w] == ra) val = wd[w];
        if (ra == '0) val = '0;
      end

      assign rd_data[IDX*DATA_W +: DATA_W] = val;
    end
  end

endmodule

// File: rtl/cluster_regfile_chk.sv
module cluster_regfile_chk #(
  parameter int N_ISSUE   = 4,
  parameter int N_CLUSTER = 2,
  parameter int N_REGS    = 32,
  parameter int DATA_W    = 32,
  localparam int AW       = $clog2(N_REGS),
  localparam int N_RD     = 2 * N_ISSUE
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_ISSUE-1:0]        wr_en,
  input logic [N_ISSUE*AW-1:0]     wr_addr,
  input logic [N_ISSUE*DATA_W-1:0] wr_data,
  input logic [N_RD*AW-1:0]        rd_addr,
  input logic [N_RD*DATA_W-1:0]    rd_data
);

  logic [AW-1:0]     wa [N_ISSUE];
  logic [DATA_W-1:0] wd [N_ISSUE];
  logic [AW-1:0]     ra [N_RD];
  logic [DATA_W-1:0] rd [N_RD];
  logic [N_RD-1:0]   hit;
  logic              started;

  for (genvar w = 0; w < N_ISSUE; w++) begin : g_w
    assign wa[w] = wr_addr[w*AW +: AW];
    assign wd[w] = wr_data[w*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;

  for (genvar i = 0; i < N_RD; i++) begin : g_r
    assign ra[i] = rd_addr[i*AW +: AW];
    assign rd[i] = rd_data[i*DATA_W +: DATA_W];

    always_comb begin
      hit[i] = 1'b0;
      for (int w = 0; w < N_ISSUE; w++)
        if (wr_en[w] && wa[w] == ra[i]) hit[i] = 1'b1;
    end

    // R5
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ra[i] == '0 |-> rd[i] == '0);

    // R8
    replica_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ra[i] == ra[0] |-> rd[i] == rd[0]);

    // R4 (also R3)
    young_port_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[N_ISSUE-1] && wa[N_ISSUE-1] == ra[i] && ra[i] != '0)
        |-> rd[i] == wd[N_ISSUE-1]);

    // R2
    broadcast_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(wr_en[N_ISSUE-1]) && $past(wa[N_ISSUE-1]) != '0 &&
       ra[i] == $past(wa[N_ISSUE-1]) && !hit[i])
        |-> rd[i] == $past(wd[N_ISSUE-1]));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(wr_en) == '0 && $stable(ra[i]) && !hit[i])
        |-> $stable(rd[i]));
  end

endmodule

bind cluster_regfile cluster_regfile_chk #(
  .N_ISSUE(N_ISSUE), .N_CLUSTER(N_CLUSTER), .N_REGS(N_REGS), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/cluster_regfile_tb.sv
module cluster_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int K   = 2;
  localparam int NR  = 32;
  localparam int DW  = 32;
  localparam int AW  = $clog2(NR);
  localparam int NRD = 2 * N;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      wr_en = '0;
  logic [N*AW-1:0]   wr_addr = '0;
  logic [N*DW-1:0]   wr_data = '0;
  logic [NRD*AW-1:0] rd_addr = '0;
  logic [NRD*DW-1:0] rd_data;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] model [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_regfile #(.N_ISSUE(N), .N_CLUSTER(K), .N_REGS(NR), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] pat(int a, int salt);
    return (DW'(a) * 32'h9E37_79B1) ^ (DW'(salt) << 24) ^ 32'h0000_5A5A;
  endfunction

  task automatic clr_wr();
    wr_en = '0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic set_wr(int w, int a, logic [DW-1:0] d);
    wr_en[w] = 1'b1;
    wr_addr[w*AW +: AW] = AW'(a);
    wr_data[w*DW +: DW] = d;
  endtask

  task automatic rd_all(int a);
    for (int i = 0; i < NRD; i++) rd_addr[i*AW +: AW] = AW'(a);
  endtask

  task automatic check(string req, int port, logic [DW-1:0] exp);
    logic [DW-1:0] got;
    got = rd_data[port*DW +: DW];
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s lane %0d got %h expected %h", req, port, got, exp);
    end
  endtask

  task automatic check_all(string req, logic [DW-1:0] exp);
    for (int i = 0; i < NRD; i++) check(req, i, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    for (int r = 0; r < NR; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every register zero after reset
    for (int a = 0; a < NR; a++) begin
      rd_all(a); #1;
      check_all("R1", '0);
    end

    // R2: each register written through a rotating port, read on all lanes
    for (int a = 1; a < NR; a++) begin
      clr_wr();
      d = pat(a, 1);
      set_wr(a % N, a, d);
      rd_all(0);
      tick();
      model[a] = d;
      clr_wr();
      rd_all(a); #1;
      check_all("R2", model[a]);
    end

    // R6: independent addressing per lane
    for (int i = 0; i < NRD; i++) rd_addr[i*AW +: AW] = AW'((i * 5 + 3) % NR);
    #1;
    for (int i = 0; i < NRD; i++) check("R6", i, model[(i * 5 + 3) % NR]);

    // R3: same-cycle forwarding on each write port, then stored value
    for (int w = 0; w < N; w++) begin
      clr_wr();
      d = pat(7 + w, 2 + w);
      set_wr(w, 7 + w, d);
      rd_all(7 + w); #1;
      check_all("R3", d);
      tick();
      model[7 + w] = d;
      clr_wr(); #1;
      check_all("R3", model[7 + w]);
    end

    // R4: all ports collide, youngest port wins
    clr_wr();
    for (int w = 0; w < N; w++) set_wr(w, 20, pat(20, 10 + w));
    rd_all(20); #1;
    check_all("R4", pat(20, 10 + N - 1));
    tick();
    model[20] = pat(20, 10 + N - 1);
    clr_wr(); #1;
    check_all("R4", model[20]);

    // R4: ports 0 and 1 collide, port 1 wins
    set_wr(0, 21, pat(21, 30));
    set_wr(1, 21, pat(21, 31));
    rd_all(21); #1;
    check_all("R4", pat(21, 31));
    tick();
    model[21] = pat(21, 31);
    clr_wr(); #1;
    check_all("R4", model[21]);

    // R4: top port disabled, next highest wins
    for (int w = 0; w < N - 1; w++) set_wr(w, 22, pat(22, 40 + w));
    rd_all(22); #1;
    check_all("R4", pat(22, 40 + N - 2));
    tick();
    model[22] = pat(22, 40 + N - 2);
    clr_wr(); #1;
    check_all("R4", model[22]);

    // R5: writes to register 0 dropped
    for (int w = 0; w < N; w++) set_wr(w, 0, pat(0, 50 + w) | 32'h1);
    rd_all(0); #1;
    check_all("R5", '0);
    tick();
    clr_wr(); #1;
    check_all("R5", '0);

    // R7: fully driven ports with enable low change nothing
    for (int w = 0; w < N; w++) set_wr(w, 5, ~pat(5, 60 + w));
    wr_en = '0;
    rd_all(5); #1;
    check_all("R7", model[5]);
    tick();
    #1;
    check_all("R7", model[5]);
    clr_wr();

    // R8: mixed addresses, lanes sharing a register agree
    for (int i = 0; i < NRD; i++) rd_addr[i*AW +: AW] = AW'((i % 3) + 20);
    #1;
    for (int i = 0; i < NRD; i++) check("R8", i, model[(i % 3) + 20]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule